// File: doc/BRIEF.md
# Hit Count Histogram Engine

This block keeps a running hit count for every channel of every chip during a threshold scan. Each incoming event carries a chip number, a channel number and a 3-bit hit pattern, where the leftmost bit is the earliest of the three samples. A pattern filter decides whether the event counts. It applies one of eight selectable modes. A hit that passes the filter is held on a last-in-first-out stack. A single update engine pops one entry at a time and adds one to the matching counter with a fixed six-cycle read, increment and write sequence. The counter sits in the histogram block chosen by a base register. A new block can be used for every scan point, so old results stay in place until a full clear.

The host side is made of plain control pins. A base write selects the block and rewinds the readout pointer. A read request returns the count at the pointer one cycle later and steps the pointer on. A clear request zeroes the whole memory. The `busy` flag tells the host when a request will be honoured. The event input is a valid/ready stream. `ev_ready` drops only while a clear is running or being requested, and an event is taken on every cycle where `ev_valid` and `ev_ready` are both high. When the stack is full, a hit is not stalled. It is dropped and the sticky `overflow_err` flag is raised. The memory geometry (blocks, chips, channels) and the counter width are parameters. The default geometry is small, and the full-size geometry uses 8/4/7 address bits.

Top module: `hist_engine`

## Requirements
- R1: The counter address is {base, chip, channel}, and one block holds 2^(CHIP_W+CHAN_W) entries. A base write sets the block and resets the readout pointer to entry 0. It takes effect only while `busy` is low, and it takes priority over a read request in the same cycle.
- R2: Filter modes on `mode`, with pattern bit 2 the first sample: 0 accepts any pattern with at least one 1. Mode 1 accepts patterns whose bit 1 is 1. Mode 2 accepts bit2=0 with bit1=1. Mode 3 accepts every pattern.
- R3: Mode 4 accepts only 3'b111, mode 5 only 3'b100, mode 6 only 3'b010 and mode 7 only 3'b001. A rejected event leaves every counter and flag unchanged.
- R4: Accepted hits are held on a STACK_DEPTH-entry stack. A push and a pop in the same cycle are both honoured.
- R5: One hit costs exactly 6 cycles of busy time. A lone hit keeps `busy` high for 6 cycles, and queued hits are updated one after another.
- R6: A counter that holds all ones stays at all ones when it is incremented.
- R7: A hit that arrives when the stack already holds STACK_DEPTH entries is dropped and sets `overflow_err`. The flag stays set until a clear is accepted.
- R8: An accepted clear zeroes every entry of every block and keeps `busy` high for 2^ADDR_W cycles. `ev_ready` is low while the clear runs and in any cycle where `clear_req` is high. A clear is accepted only when `busy` is low.
- R9: A read request accepted while `busy` is low gives `rd_valid` high on the next cycle, with `rd_data` equal to the count at the pointer. The pointer then advances and wraps inside the block. A read request made while `busy` is high is ignored.
- R10: `busy` is high exactly when a clear is running, an update is in progress or the stack is not empty.
- R11: After reset, `busy`, `rd_valid` and `overflow_err` are low and `ev_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_valid | input | 1 | Event present |
| ev_ready | output | 1 | Event accepted when high |
| ev_chip | input | CHIP_W (2) | Chip number of the event |
| ev_chan | input | CHAN_W (5) | Channel number of the event |
| ev_pattern | input | 3 | Hit pattern, bit 2 earliest sample |
| mode | input | 3 | Filter mode 0..7 |
| base_we | input | 1 | Base register write strobe |
| base_in | input | BLK_W (2) | New block number |
| clear_req | input | 1 | Request a full memory clear |
| rd_req | input | 1 | Request one readout word |
| rd_valid | output | 1 | Readout word valid |
| rd_data | output | COUNT_W (16) | Readout count |
| busy | output | 1 | Clear, update or pending hits in progress |
| overflow_err | output | 1 | Sticky stack overflow flag |

## Verification
The bench drives every mode against all eight patterns. A swapped or off-by-one filter term would show up as a counter of one where zero is expected, or the other way round. It sends a burst of back-to-back hits larger than the stack. An engine with the wrong full test would either fail to raise `overflow_err` or lose counts. It also checks that the flag survives until a clear. Busy time is timed for a single hit and for a full clear, so a five- or seven-cycle update, or a clear one cycle short, is caught. Pushing a counter past its top value catches wrapping, reading past the end of a block catches a pointer that escapes the block, and base writes and reads made while busy must leave the pointer and the outputs unchanged.

// File: rtl/hist_pkg.sv
package hist_pkg;

  typedef enum logic [2:0] {
    PM_ANY_HIT = 3'd0,
    PM_MIDDLE  = 3'd1,
    PM_RISE    = 3'd2,
    PM_ALL     = 3'd3,
    PM_TRIPLE  = 3'd4,
    PM_FIRST   = 3'd5,
    PM_SECOND  = 3'd6,
    PM_THIRD   = 3'd7
  } pat_mode_e;

  localparam int unsigned UPDATE_STEPS = 6;

endpackage

// File: rtl/hist_pattern_filter.sv
module hist_pattern_filter
  import hist_pkg::*;
(
  input  logic [2:0] mode,
  input  logic [2:0] pattern,
  output logic       hit
);
  always_comb begin
    unique case (pat_mode_e'(mode))
      PM_ANY_HIT: hit = |pattern;
      PM_MIDDLE:  hit = pattern[1];
      PM_RISE:    hit = ~pattern[2] & pattern[1];
      PM_ALL:     hit = 1'b1;
      PM_TRIPLE:  hit = (pattern == 3'b111);
      PM_FIRST:   hit = (pattern == 3'b100);
      PM_SECOND:  hit = (pattern == 3'b010);
      default:    hit = (pattern == 3'b001);
    endcase
  end
endmodule

// File: rtl/hist_lifo.sv
module hist_lifo #(
  parameter int W     = 7,
  parameter int DEPTH = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic [W-1:0] top_data,
  output logic         full,
  output logic         empty
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  slots [DEPTH];
  logic [CW-1:0] fill;
  logic [AW-1:0] top_idx;
  logic [AW-1:0] next_idx;

  assign top_idx  = AW'(fill - CW'(1));
  assign next_idx = AW'(fill);
  assign top_data = slots[top_idx];
  assign full     = (fill == CW'(DEPTH));
  assign empty    = (fill == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fill <= '0;
    end else if (push && !pop) begin
      fill <= fill + CW'(1);
    end else if (pop && !push) begin
      fill <= fill - CW'(1);
    end
  end

  // push with pop replaces the popped top slot in place
  always_ff @(posedge clk) begin
    if (push && pop)  slots[top_idx]  <= push_data;
    else if (push)    slots[next_idx] <= push_data;
  end
endmodule

// File: rtl/hist_count_mem.sv
module hist_count_mem #(
  parameter int AW = 9,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] cells [DEPTH];

  assign rdata = cells[raddr];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end
endmodule

// File: rtl/hist_engine.sv
module hist_engine
  import hist_pkg::*;
#(
  parameter int BLK_W       = 2,
  parameter int CHIP_W      = 2,
  parameter int CHAN_W      = 5,
  parameter int COUNT_W     = 16,
  parameter int STACK_DEPTH = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_valid,
  output logic              ev_ready,
  input  logic [CHIP_W-1:0] ev_chip,
  input  logic [CHAN_W-1:0] ev_chan,
  input  logic [2:0]        ev_pattern,
  input  logic [2:0]        mode,
  input  logic              base_we,
  input  logic [BLK_W-1:0]  base_in,
  input  logic              clear_req,
  input  logic              rd_req,
  output logic              rd_valid,
  output logic [COUNT_W-1:0] rd_data,
  output logic              busy,
  output logic              overflow_err
);
  localparam int ENT_W     = CHIP_W + CHAN_W;
  localparam int ADDR_W    = BLK_W + ENT_W;
  localparam int STEP_W    = 3;
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(UPDATE_STEPS - 1);

  logic               pat_hit, ev_fire, ev_hit, push, pop;
  logic               lifo_full, lifo_empty;
  logic [ENT_W-1:0]   lifo_top;
  logic               clear_go, base_go, read_go;

  logic [BLK_W-1:0]   base_q;
  logic [ENT_W-1:0]   rd_ptr;
  logic               ovf_q, clearing;
  logic [ADDR_W-1:0]  clr_ptr;
  logic               upd_active;
  logic [STEP_W-1:0]  upd_step;
  logic [ENT_W-1:0]   upd_ent;
  logic [COUNT_W-1:0] upd_val;
  logic               rd_valid_q;
  logic [COUNT_W-1:0] rd_data_q;

  logic               mem_we;
  logic [ADDR_W-1:0]  mem_waddr, mem_raddr;
  logic [COUNT_W-1:0] mem_wdata, mem_rdata;

  hist_pattern_filter u_filter (
    .mode    (mode),
    .pattern (ev_pattern),
    .hit     (pat_hit)
  );

  assign busy     = clearing | upd_active | ~lifo_empty;
  assign ev_ready = ~(clearing | clear_req);
  assign ev_fire  = ev_valid & ev_ready;
  assign ev_hit   = ev_fire & pat_hit;
  assign push     = ev_hit & ~lifo_full;
  assign pop      = ~upd_active & ~lifo_empty & ~clearing;
  assign clear_go = clear_req & ~busy;
  assign base_go  = base_we & ~busy;
  assign read_go  = rd_req & ~busy & ~base_we;

  hist_lifo #(.W(ENT_W), .DEPTH(STACK_DEPTH)) u_lifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (push),
    .push_data ({ev_chip, ev_chan}),
    .pop       (pop),
    .top_data  (lifo_top),
    .full      (lifo_full),
    .empty     (lifo_empty)
  );

  assign mem_raddr = upd_active ? {base_q, upd_ent} : {base_q, rd_ptr};
  assign mem_we    = clearing | (upd_active & (upd_step == LAST_STEP));
  assign mem_waddr = clearing ? clr_ptr : {base_q, upd_ent};
  assign mem_wdata = clearing ? '0 : upd_val;

  hist_count_mem #(.AW(ADDR_W), .DW(COUNT_W)) u_mem (
    .clk   (clk),
    .we    (mem_we),
    .waddr (mem_waddr),
    .wdata (mem_wdata),
    .raddr (mem_raddr),
    .rdata (mem_rdata)
  );

  // read-modify-write sequencer: pop, read, increment, two holds, write
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      upd_active <= 1'b0;
      upd_step   <= '0;
      upd_ent    <= '0;
      upd_val    <= '0;
    end else if (pop) begin
      upd_active <= 1'b1;
      upd_step   <= STEP_W'(1);
      upd_ent    <= lifo_top;
    end else if (upd_active) begin
      case (upd_step)
        STEP_W'(1): upd_val <= mem_rdata;
        STEP_W'(2): upd_val <= (&upd_val) ? upd_val : upd_val + COUNT_W'(1);
        default:    upd_val <= upd_val;
      endcase
      if (upd_step == LAST_STEP) begin
        upd_active <= 1'b0;
        upd_step   <= '0;
      end else begin
        upd_step <= upd_step + STEP_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      clearing <= 1'b0;
      clr_ptr  <= '0;
    end else if (clear_go) begin
      clearing <= 1'b1;
      clr_ptr  <= '0;
    end else if (clearing) begin
      clr_ptr <= clr_ptr + ADDR_W'(1);
      if (&clr_ptr) clearing <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        ovf_q <= 1'b0;
    else if (clear_go) ovf_q <= 1'b0;
    else if (ev_hit && lifo_full) ovf_q <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q     <= '0;
      rd_ptr     <= '0;
      rd_valid_q <= 1'b0;
      rd_data_q  <= '0;
    end else begin
      rd_valid_q <= read_go;
      if (base_go) begin
        base_q <= base_in;
        rd_ptr <= '0;
      end else if (read_go) begin
        rd_data_q <= mem_rdata;
        rd_ptr    <= rd_ptr + ENT_W'(1);
      end
    end
  end

  assign rd_valid     = rd_valid_q;
  assign rd_data      = rd_data_q;
  assign overflow_err = ovf_q;
endmodule

// File: rtl/hist_engine_chk.sv
module hist_engine_chk (
  input logic clk,
  input logic rst_n,
  input logic ev_valid,
  input logic ev_ready,
  input logic clear_req,
  input logic rd_req,
  input logic rd_valid,
  input logic busy,
  input logic overflow_err
);
  assert_ready_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_ready |-> (busy || clear_req));

  assert_read_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(rd_req && !busy));

  assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!overflow_err && $past(overflow_err)) |-> $past(clear_req && !busy));

  assert_err_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overflow_err) |-> $past(ev_valid && busy));

  assert_busy_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(ev_valid || clear_req));
endmodule

bind hist_engine hist_engine_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .ev_valid     (ev_valid),
  .ev_ready     (ev_ready),
  .clear_req    (clear_req),
  .rd_req       (rd_req),
  .rd_valid     (rd_valid),
  .busy         (busy),
  .overflow_err (overflow_err)
);

// File: tb/hist_engine_test.sv
module hist_engine_test;
  localparam int CW    = 8;
  localparam int BS    = 128;
  localparam int DEPTH = 512;
  localparam int SDEP  = 64;
  localparam int MAXC  = (1 << CW) - 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ev_valid = 0, base_we = 0, clear_req = 0, rd_req = 0;
  logic [1:0] ev_chip = 0, base_in = 0;
  logic [4:0] ev_chan = 0;
  logic [2:0] ev_pattern = 0, mode = 0;
  logic ev_ready, rd_valid, busy, overflow_err;
  logic [CW-1:0] rd_data;

  int checks = 0, errors = 0, cycles = 0;
  bit done = 0;

  hist_engine #(.COUNT_W(CW)) uut (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_ready(ev_ready),
    .ev_chip(ev_chip), .ev_chan(ev_chan), .ev_pattern(ev_pattern), .mode(mode),
    .base_we(base_we), .base_in(base_in), .clear_req(clear_req), .rd_req(rd_req),
    .rd_valid(rd_valid), .rd_data(rd_data), .busy(busy), .overflow_err(overflow_err));

  // reference model state
  int mem_m [DEPTH];
  int stk_m [$];
  bit act_m = 0, ovf_m = 0, rdv_m = 0;
  int step_m = 0, ent_m = 0, clr_left = 0, base_m = 0, ptr_m = 0, rdd_m = 0;

  function automatic bit accepts(int md, int p);
    bit first = p[2], second = p[1], third = p[0];
    case (md)
      0: return first || second || third;
      1: return second;
      2: return !first && second;
      3: return 1;
      4: return first && second && third;
      5: return first && !second && !third;
      6: return !first && second && !third;
      default: return !first && !second && third;
    endcase
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  always begin
    #4 clk = ~clk;
    if (clk) begin
      cycles++;
      if (cycles > 150000) begin
        checks++; errors++;
        $display("FAIL watchdog: run hung, actual %0d cycles expected < 150000", cycles);
        finish_run();
      end
    end
  end

  always @(posedge clk) begin
    bit busy_pre, full_pre, rdy_pre;
    busy_pre = (clr_left > 0) || act_m || (stk_m.size() > 0);
    full_pre = (stk_m.size() == SDEP);
    rdy_pre  = !((clr_left > 0) || clear_req);
    if (!rst_n) begin
      stk_m.delete(); act_m = 0; ovf_m = 0; rdv_m = 0; step_m = 0;
      clr_left = 0; base_m = 0; ptr_m = 0;
    end else begin
      rdv_m = 0;
      if (base_we && !busy_pre) begin
        base_m = base_in; ptr_m = 0;
      end else if (rd_req && !busy_pre) begin
        rdv_m = 1; rdd_m = mem_m[base_m * BS + ptr_m]; ptr_m = (ptr_m + 1) % BS;
      end
      if (!act_m && stk_m.size() > 0 && clr_left == 0) begin
        ent_m = stk_m.pop_back(); act_m = 1; step_m = 1;
      end else if (act_m) begin
        if (step_m == 5) begin
          if (mem_m[base_m * BS + ent_m] < MAXC) mem_m[base_m * BS + ent_m]++;
          act_m = 0;
        end else step_m++;
      end
      if (ev_valid && rdy_pre && accepts(int'(mode), int'(ev_pattern))) begin
        if (full_pre) ovf_m = 1;
        else stk_m.push_back(int'(ev_chip) * 32 + int'(ev_chan));
      end
      if (clr_left > 0) clr_left--;
      if (clear_req && !busy_pre) begin
        clr_left = DEPTH; ovf_m = 0;
        foreach (mem_m[i]) mem_m[i] = 0;
      end
    end
  end

  task automatic check(bit ok, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  // cycle-by-cycle comparison against the model, away from the clock edge
  always begin
    @(negedge clk); #2;
    if (rst_n) begin
      bit b, r;
      b = (clr_left > 0) || act_m || (stk_m.size() > 0);
      r = !((clr_left > 0) || clear_req);
      check(busy == b, "R10 R5 busy", int'(busy), int'(b));
      check(ev_ready == r, "R8 ev_ready", int'(ev_ready), int'(r));
      check(overflow_err == ovf_m, "R7 overflow_err", int'(overflow_err), int'(ovf_m));
      check(rd_valid == rdv_m, "R9 rd_valid", int'(rd_valid), int'(rdv_m));
      if (rdv_m)
        check(int'(rd_data) == rdd_m, "R1 R2 R3 R4 R6 rd_data", int'(rd_data), rdd_m);
    end
  end

  task automatic send_ev(int md, int ent, int pat);
    @(negedge clk);
    ev_valid = 1; mode = 3'(md); ev_chip = 2'(ent / 32); ev_chan = 5'(ent % 32);
    ev_pattern = 3'(pat);
    @(negedge clk);
    ev_valid = 0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
  endtask

  task automatic do_clear(output int dur);
    @(negedge clk); clear_req = 1;
    @(negedge clk); clear_req = 0;
    dur = 0;
    while (busy) begin dur++; @(negedge clk); end
  endtask

  task automatic set_base(int b);
    @(negedge clk); base_we = 1; base_in = 2'(b);
    @(negedge clk); base_we = 0;
  endtask

  task automatic read_n(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); rd_req = 1;
    end
    @(negedge clk); rd_req = 0;
    @(negedge clk);
  endtask

  initial begin
    int dur;
    repeat (3) @(negedge clk);
    check(busy == 0, "R11 busy after reset", int'(busy), 0);
    check(rd_valid == 0, "R11 rd_valid after reset", int'(rd_valid), 0);
    check(overflow_err == 0, "R11 overflow_err after reset", int'(overflow_err), 0);
    check(ev_ready == 1, "R11 ev_ready after reset", int'(ev_ready), 1);
    rst_n = 1;

    do_clear(dur);
    check(dur == DEPTH, "R8 clear duration", dur, DEPTH);

    // filter sweep, every mode against every pattern
    set_base(1);
    for (int md = 0; md < 8; md++)
      for (int p = 0; p < 8; p++) begin
        send_ev(md, md * 8 + p, p);
        wait_idle();
      end
    read_n(BS);

    // a lone hit costs six busy cycles
    send_ev(3, 5, 0);
    dur = 0;
    while (busy) begin dur++; @(negedge clk); end
    check(dur == 6, "R5 busy cycles per hit", dur, 6);

    // burst larger than the stack, with base/read attempts while busy
    set_base(3);
    @(negedge clk);
    for (int i = 0; i < 80; i++) begin
      ev_valid = 1; mode = 3'd3; ev_chip = 2'((i % 64) / 32); ev_chan = 5'(i % 32);
      ev_pattern = 3'(i);
      @(negedge clk);
    end
    ev_valid = 0;
    check(overflow_err == 1, "R7 overflow after burst", int'(overflow_err), 1);
    base_we = 1; base_in = 2'd0; @(negedge clk); base_we = 0;
    rd_req = 1; @(negedge clk); rd_req = 0; @(negedge clk);
    check(rd_valid == 0, "R9 read ignored while busy", int'(rd_valid), 0);
    wait_idle();
    check(overflow_err == 1, "R7 overflow sticky", int'(overflow_err), 1);
    read_n(BS + 3);

    // saturation of one counter
    set_base(2);
    for (int i = 0; i < MAXC + 5; i++) begin
      send_ev(5, 0, 4);
      wait_idle();
    end
    set_base(2);
    @(negedge clk); rd_req = 1; @(negedge clk); rd_req = 0; #2;
    check(int'(rd_data) == MAXC, "R6 saturated count", int'(rd_data), MAXC);
    read_n(3);

    // clear drops the flag and zeroes the blocks
    do_clear(dur);
    check(overflow_err == 0, "R7 flag cleared by clear", int'(overflow_err), 0);
    set_base(3);
    read_n(8);

    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule